// File: doc/BRIEF.md
# Bridge Register-Access Command Sequencer

This block sits on the host side of a byte-wide serial bridge. It turns one high-level request, "write this device register" or "read this device register", into the complete sequence of single-cycle accesses on a small memory-mapped bus. The bus carries an address, write data, read data and separate write and read strobes. The bridge has two registers that matter here: a transfer buffer that passes bytes to and from the device, and a status register. In the status register, one bit reports that the buffer can accept a byte and another reports that a received byte is waiting.

Straight after reset the sequencer programs four bridge configuration registers, once. It then waits for commands. A write command sends the device register address, then a chosen number of data bytes with the most significant first, then consumes the single byte the device returns. A read command sends the address and a chosen number of request bytes, then reads exactly eight response bytes and assembles them into a 64-bit word, first byte on top. Every byte in either direction is preceded by status polling. A poll that runs too long ends the command and raises a sticky error.

Top module: `brg_cmd_seq`

## Requirements
- R1: While reset is held, busy is 1, done is 0, timeout_err is 0, rsp_data is 0 and no strobe is active. After reset, the block issues exactly four bus writes, in this order: offset 0x00 value 0x07, offset 0x01 value 0x00, offset 0x03 value 0x0D, offset 0x02 value 0x07. It issues no read during them, and then drops busy.
- R2: Every write to the transfer buffer (offset 0x00) outside the start-up writes comes after a read of the status register (offset 0x05). That status read must be the most recent one, it must have returned bit 7 = 1, and it must have come after the previous transfer-buffer access.
- R3: Every read of the transfer buffer comes after a status read with the same conditions, except that the status read must have returned bit 0 = 1.
- R4: A write command (cmd_is_read = 0) sends cmd_addr first. It then sends the low N bytes of cmd_data, most significant of those first. N is cmd_len when cmd_len is 1 to 8, and N is 8 when cmd_len is 0 or above 8.
- R5: After the last data byte of a write command, the block reads exactly one byte from the transfer buffer and discards it. rsp_data keeps its previous value.
- R6: A read command (cmd_is_read = 1) sends cmd_addr, then the low M bytes of cmd_data, most significant first. M is cmd_req_len, clamped to 8. The block then reads exactly eight bytes from the transfer buffer, and rsp_data becomes those bytes with the first one received in bits 63:56.
- R7: busy is 1 from the cycle after a command is accepted until the cycle in which done is 1. done is a single-cycle pulse, and busy is 0 in that cycle.
- R8: A cmd_valid presented while busy is 1 is ignored. It adds no bus transfer and no extra done pulse.
- R9: Each read strobe lasts one cycle, the status data is judged in the cycle after it, and the write and read strobes are never active together.
- R10: Within one status wait, let L be the poll_limit sampled with the command. After L+1 consecutive not-ready status reads, timeout_err becomes 1 and stays 1 until reset, busy falls, and done does not pulse. With L not-ready reads followed by a ready one, the command completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_is_read | input | 1 | 1 = register read, 0 = register write |
| cmd_addr | input | 8 | Device register address byte |
| cmd_len | input | 4 | Data byte count for a write (1..8, 0 or above 8 means 8) |
| cmd_req_len | input | 4 | Request byte count for a read (0..8, clamped to 8) |
| cmd_data | input | 64 | Data or request bytes, right-aligned |
| poll_limit | input | 16 | Not-ready status reads tolerated per byte wait |
| busy | output | 1 | Start-up or command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 64 | Assembled read response |
| timeout_err | output | 1 | Sticky poll timeout flag |
| bus_addr | output | 8 | Bridge register offset |
| bus_wdata | output | 8 | Bridge write data |
| bus_we | output | 1 | Bridge write strobe |
| bus_re | output | 1 | Bridge read strobe |
| bus_rdata | input | 8 | Bridge read data, valid the cycle after bus_re |

## Verification
The assertions assume a bridge that returns read data exactly one cycle after each read strobe. They also assume the bridge only reports a waiting receive byte when one is actually queued, because the grant tracking treats a status bit at 1 as permission for the next transfer. The bench model keeps to these rules: it answers every strobe with registered data one cycle later, it reports bit 0 only while its response queue is non-empty, and it injects not-ready status reads only as whole replies. Commands are driven only on falling edges and held for one cycle. Every command except the deliberately ignored one is issued only after busy has fallen.

// File: rtl/brg_seq_pkg.sv
package brg_seq_pkg;

  typedef enum logic [2:0] {
    S_BOOT,
    S_INIT,
    S_IDLE,
    S_PREQ,
    S_PCHK,
    S_TX,
    S_RREQ,
    S_RCAP
  } seq_state_t;

endpackage

// File: rtl/brg_init_table.sv
module brg_init_table #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] ofs,
  output logic [DW-1:0] val
);

  // start-up configuration writes, issued in index order
  always_comb begin
    case (idx)
      IW'(0):  begin ofs = AW'(8'h00); val = DW'(8'h07); end
      IW'(1):  begin ofs = AW'(8'h01); val = DW'(8'h00); end
      IW'(2):  begin ofs = AW'(8'h03); val = DW'(8'h0D); end
      IW'(3):  begin ofs = AW'(8'h02); val = DW'(8'h07); end
      default: begin ofs = '0;         val = '0;         end
    endcase
  end

endmodule

// File: rtl/brg_poll_timer.sv
module brg_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] misses;

  always_ff @(posedge clk) begin
    if (rst || clr) misses <= '0;
    else if (inc)   misses <= misses + TW'(1);
  end

  // true once 'limit' not-ready replies have already been seen
  assign expired = (misses == limit);

endmodule

// File: rtl/brg_byte_pack.sv
module brg_byte_pack #(
  parameter int DW   = 8,
  parameter int MAXB = 8,
  parameter int RSPB = 8,
  parameter int CW   = 4,
  localparam int WW  = MAXB * DW,
  localparam int RW  = RSPB * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [WW-1:0] load_data,
  input  logic [CW-1:0] load_n,
  input  logic          shift,
  output logic [DW-1:0] tx_byte,
  input  logic          cap,
  input  logic [DW-1:0] cap_byte,
  output logic [RW-1:0] acc_next
);

  logic [WW-1:0]    tx_sr;
  logic [RW-DW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
    end else if (load) begin
      // left-align the used bytes so the most significant leaves first
      tx_sr <= load_data << (DW * (MAXB - int'(load_n)));
    end else if (shift) begin
      tx_sr <= tx_sr << DW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) acc <= '0;
    else if (cap)    acc <= acc_next[RW-DW-1:0];
  end

  assign tx_byte  = tx_sr[WW-1 -: DW];
  assign acc_next = {acc, cap_byte};

endmodule

// File: rtl/brg_cmd_seq.sv
module brg_cmd_seq
  import brg_seq_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int MAXB     = 8,
  parameter int RSPB     = 8,
  parameter int TW       = 16,
  parameter int LW       = 4,
  parameter int NINIT    = 4,
  parameter logic [AW-1:0] XFER_OFS = 8'h00,
  parameter logic [AW-1:0] STAT_OFS = 8'h05,
  parameter int TX_BIT   = 7,
  parameter int RX_BIT   = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic                 cmd_is_read,
  input  logic [DW-1:0]        cmd_addr,
  input  logic [LW-1:0]        cmd_len,
  input  logic [LW-1:0]        cmd_req_len,
  input  logic [MAXB*DW-1:0]   cmd_data,
  input  logic [TW-1:0]        poll_limit,
  output logic                 busy,
  output logic                 done,
  output logic [RSPB*DW-1:0]   rsp_data,
  output logic                 timeout_err,
  output logic [AW-1:0]        bus_addr,
  output logic [DW-1:0]        bus_wdata,
  output logic                 bus_we,
  output logic                 bus_re,
  input  logic [DW-1:0]        bus_rdata
);

  localparam int WW  = MAXB * DW;
  localparam int RW  = RSPB * DW;
  localparam int CW  = $clog2(MAXB + 2);
  localparam int RCW = $clog2(RSPB + 1);
  localparam int IW  = (NINIT > 1) ? $clog2(NINIT) : 1;

  seq_state_t st, st_n;

  logic [IW-1:0]  init_idx, init_idx_n;
  logic [AW-1:0]  ini_ofs;
  logic [DW-1:0]  ini_val;
  logic [DW-1:0]  addr_r;
  logic           is_rd;
  logic           first;
  logic [CW-1:0]  tx_left;
  logic [RCW-1:0] rx_left;
  logic [TW-1:0]  lim_r;
  logic [CW-1:0]  n_eff;
  logic [LW-1:0]  len_sel;
  logic           ready;
  logic           tmr_exp;
  logic           accept;
  logic [DW-1:0]  tx_byte;
  logic [RW-1:0]  acc_next;
  logic           boot_phase;

  // ---------------------------------------------------------------
  // byte count clamp for the incoming command
  // ---------------------------------------------------------------
  always_comb begin
    len_sel = cmd_is_read ? cmd_req_len : cmd_len;
    if (int'(len_sel) > MAXB)
      n_eff = CW'(MAXB);
    else if (!cmd_is_read && (len_sel == '0))
      n_eff = CW'(MAXB);
    else
      n_eff = CW'(len_sel);
  end

  assign accept     = (st == S_IDLE) && cmd_valid;
  assign ready      = (tx_left != '0) ? bus_rdata[TX_BIT] : bus_rdata[RX_BIT];
  assign init_idx_n = (st == S_INIT) ? init_idx + IW'(1) : '0;
  assign boot_phase = (st == S_BOOT) || (st == S_INIT);

  brg_init_table #(.AW(AW), .DW(DW), .N(NINIT)) u_init (
    .idx (init_idx_n),
    .ofs (ini_ofs),
    .val (ini_val)
  );

  brg_poll_timer #(.TW(TW)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clr     (!((st == S_PREQ) || (st == S_PCHK))),
    .inc     ((st == S_PCHK) && !ready),
    .limit   (lim_r),
    .expired (tmr_exp)
  );

  brg_byte_pack #(.DW(DW), .MAXB(MAXB), .RSPB(RSPB), .CW(CW)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_data (cmd_data),
    .load_n    (n_eff),
    .shift     ((st == S_TX) && !first),
    .tx_byte   (tx_byte),
    .cap       ((st == S_RCAP) && is_rd),
    .cap_byte  (bus_rdata),
    .acc_next  (acc_next)
  );

  // ---------------------------------------------------------------
  // next state
  // ---------------------------------------------------------------
  always_comb begin
    st_n = st;
    case (st)
      S_BOOT: st_n = S_INIT;
      S_INIT: st_n = (init_idx == IW'(NINIT - 1)) ? S_IDLE : S_INIT;
      S_IDLE: if (cmd_valid) st_n = S_PREQ;
      S_PREQ: st_n = S_PCHK;
      S_PCHK: begin
        if (ready)        st_n = (tx_left != '0) ? S_TX : S_RREQ;
        else if (tmr_exp) st_n = S_IDLE;
        else              st_n = S_PREQ;
      end
      S_TX:   st_n = S_PREQ;
      S_RREQ: st_n = S_RCAP;
      S_RCAP: st_n = (rx_left == RCW'(1)) ? S_IDLE : S_PREQ;
      default: st_n = S_IDLE;
    endcase
  end

  // ---------------------------------------------------------------
  // state, registered bus outputs and command context
  // ---------------------------------------------------------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_BOOT;
      init_idx    <= '0;
      bus_we      <= 1'b0;
      bus_re      <= 1'b0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      busy        <= 1'b1;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      rsp_data    <= '0;
      addr_r      <= '0;
      is_rd       <= 1'b0;
      first       <= 1'b0;
      tx_left     <= '0;
      rx_left     <= '0;
      lim_r       <= '0;
    end else begin
      st     <= st_n;
      done   <= 1'b0;
      bus_we <= (st_n == S_INIT) || (st_n == S_TX);
      bus_re <= (st_n == S_PREQ) || (st_n == S_RREQ);

      case (st_n)
        S_INIT: begin
          bus_addr  <= ini_ofs;
          bus_wdata <= ini_val;
          init_idx  <= init_idx_n;
        end
        S_TX: begin
          bus_addr  <= XFER_OFS;
          bus_wdata <= first ? addr_r : tx_byte;
        end
        S_PREQ:  bus_addr <= STAT_OFS;
        S_RREQ:  bus_addr <= XFER_OFS;
        default: ;
      endcase

      case (st)
        S_INIT: if (st_n == S_IDLE) busy <= 1'b0;
        S_IDLE: if (cmd_valid) begin
          busy    <= 1'b1;
          addr_r  <= cmd_addr;
          is_rd   <= cmd_is_read;
          first   <= 1'b1;
          tx_left <= n_eff + CW'(1);
          rx_left <= cmd_is_read ? RCW'(RSPB) : RCW'(1);
          lim_r   <= poll_limit;
        end
        S_PCHK: if (!ready && tmr_exp) begin
          timeout_err <= 1'b1;
          busy        <= 1'b0;
        end
        S_TX: begin
          first   <= 1'b0;
          tx_left <= tx_left - CW'(1);
        end
        S_RCAP: begin
          rx_left <= rx_left - RCW'(1);
          if (rx_left == RCW'(1)) begin
            done <= 1'b1;
            busy <= 1'b0;
            if (is_rd) rsp_data <= acc_next;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/brg_cmd_seq_chk.sv
module brg_cmd_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] XFER_OFS = 8'h00,
  parameter logic [AW-1:0] STAT_OFS = 8'h05,
  parameter int TX_BIT = 7,
  parameter int RX_BIT = 0
) (
  input logic          clk,
  input logic          rst,
  input logic          in_init,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic          bus_re,
  input logic [DW-1:0] bus_rdata,
  input logic          busy,
  input logic          done,
  input logic          timeout_err
);

  logic stat_d, tx_ok, rx_ok;

  // grants observed on the bus: last status reply, voided by a transfer
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_d <= 1'b0;
      tx_ok  <= 1'b0;
      rx_ok  <= 1'b0;
    end else begin
      stat_d <= bus_re && (bus_addr == STAT_OFS);
      if (stat_d) begin
        tx_ok <= bus_rdata[TX_BIT];
        rx_ok <= bus_rdata[RX_BIT];
      end
      if (bus_we && (bus_addr == XFER_OFS) && !in_init) tx_ok <= 1'b0;
      if (bus_re && (bus_addr == XFER_OFS))             rx_ok <= 1'b0;
    end
  end

  p_init_no_read_r1: assert property (@(posedge clk) disable iff (rst)
    in_init |-> !bus_re);

  p_tx_after_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == XFER_OFS) && !in_init) |-> tx_ok);

  p_rx_after_ready_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (bus_addr == XFER_OFS)) |-> rx_ok);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_read_single_r9: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> !bus_re);

  p_no_dual_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> timeout_err);

  p_err_stops_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> (!busy && !done));

endmodule

bind brg_cmd_seq brg_cmd_seq_chk #(
  .AW(AW), .DW(DW), .XFER_OFS(XFER_OFS), .STAT_OFS(STAT_OFS),
  .TX_BIT(TX_BIT), .RX_BIT(RX_BIT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_init     (boot_phase),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_re      (bus_re),
  .bus_rdata   (bus_rdata),
  .busy        (busy),
  .done        (done),
  .timeout_err (timeout_err)
);

// File: tb/brg_cmd_seq_test.sv
module brg_cmd_seq_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid, cmd_is_read;
  logic [7:0]  cmd_addr;
  logic [3:0]  cmd_len, cmd_req_len;
  logic [63:0] cmd_data;
  logic [15:0] poll_limit;
  logic        busy, done, timeout_err;
  logic [63:0] rsp_data;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata;
  logic        bus_we, bus_re;

  always #10 clk = ~clk;

  brg_cmd_seq uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_req_len(cmd_req_len),
    .cmd_data(cmd_data), .poll_limit(poll_limit), .busy(busy), .done(done),
    .rsp_data(rsp_data), .timeout_err(timeout_err), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata)
  );

  // configuration for the bridge model, driven only by the main sequence
  int          stall_cfg = 0;
  int          exp_tx_total = 0;
  logic [63:0] resp_word = '0;
  int          resp_n = 0;
  logic        clr_log = 1'b0;

  // bridge model state, driven only by the model process
  int          init_cnt, tx_cnt, rd_cnt, q_cnt, viol, viol9, done_cnt, stall_cnt;
  logic [63:0] init_log, q;
  logic [71:0] tx_log;
  logic        tx_grant, rx_grant, re_d;

  always @(posedge clk) begin
    if (rst) begin
      init_cnt <= 0; tx_cnt <= 0; rd_cnt <= 0; q_cnt <= 0; viol <= 0;
      viol9 <= 0; done_cnt <= 0; stall_cnt <= 0; init_log <= '0; q <= '0;
      tx_log <= '0; tx_grant <= 1'b0; rx_grant <= 1'b0; re_d <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (done) done_cnt <= done_cnt + 1;
      re_d <= bus_re;
      if ((bus_re && re_d) || (bus_re && bus_we)) viol9 <= viol9 + 1;
      if (clr_log) begin
        tx_log <= '0; tx_cnt <= 0; rd_cnt <= 0; viol <= 0; q_cnt <= 0;
        stall_cnt <= stall_cfg;
      end else begin
        if (bus_we) begin
          if (init_cnt < 4) begin
            init_log <= {init_log[47:0], bus_addr, bus_wdata};
            init_cnt <= init_cnt + 1;
          end else if (bus_addr == 8'h00) begin
            if (!tx_grant) viol <= viol + 1;
            tx_grant  <= 1'b0;
            tx_log    <= {tx_log[63:0], bus_wdata};
            tx_cnt    <= tx_cnt + 1;
            stall_cnt <= stall_cfg;
            if (tx_cnt + 1 == exp_tx_total) begin
              q     <= resp_word;
              q_cnt <= resp_n;
            end
          end else begin
            viol <= viol + 1;
          end
        end
        if (bus_re) begin
          if (bus_addr == 8'h05) begin
            if (stall_cnt > 0) begin
              bus_rdata <= 8'h00;
              stall_cnt <= stall_cnt - 1;
              tx_grant  <= 1'b0;
              rx_grant  <= 1'b0;
            end else begin
              bus_rdata <= {1'b1, 6'b0, (q_cnt != 0)};
              tx_grant  <= 1'b1;
              rx_grant  <= (q_cnt != 0);
            end
          end else if (bus_addr == 8'h00) begin
            if (!rx_grant || q_cnt == 0) viol <= viol + 1;
            rx_grant  <= 1'b0;
            bus_rdata <= q[63:56];
            q         <= q << 8;
            q_cnt     <= q_cnt - 1;
            rd_cnt    <= rd_cnt + 1;
            stall_cnt <= stall_cfg;
          end else begin
            viol <= viol + 1;
          end
        end
      end
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input logic [71:0] act,
                     input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_n(input bit rd, input int n);
    if (n > 8) return 8;
    if (!rd && n == 0) return 8;
    return n;
  endfunction

  function automatic logic [71:0] exp_stream(input logic [7:0] a, input int n,
                                             input logic [63:0] d);
    logic [71:0] m;
    m = (n == 8) ? {8'h00, {64{1'b1}}} : ((72'h1 << (8 * n)) - 72'h1);
    return ({64'h0, a} << (8 * n)) | ({8'h00, d} & m);
  endfunction

  typedef struct packed {
    logic        rd;
    logic [7:0]  addr;
    logic [3:0]  n;
    logic [63:0] data;
    logic [63:0] resp;
    logic [7:0]  stall;
    logic [15:0] lim;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h11, 4'd1,  64'h00000000000000AB, 64'h0, 8'd0, 16'd4},
    '{1'b0, 8'h22, 4'd3,  64'h0000000000123456, 64'h0, 8'd2, 16'd4},
    '{1'b0, 8'h33, 4'd8,  64'h0102030405060708, 64'h0, 8'd1, 16'd4},
    '{1'b0, 8'h44, 4'd0,  64'hF0E1D2C3B4A59687, 64'h0, 8'd0, 16'd2},
    '{1'b1, 8'h55, 4'd0,  64'h0, 64'h8877665544332211, 8'd0, 16'd2},
    '{1'b1, 8'h66, 4'd2,  64'h000000000000BEEF, 64'h0123456789ABCDEF, 8'd3, 16'd3},
    '{1'b1, 8'h77, 4'd8,  64'hA1A2A3A4A5A6A7A8, 64'hFEDCBA9876543210, 8'd1, 16'd4},
    '{1'b0, 8'h88, 4'd5,  64'h0000001122334455, 64'h0, 8'd3, 16'd3},
    '{1'b1, 8'h99, 4'd12, 64'h1020304050607080, 64'h55AA55AA0F0FF0F0, 8'd0, 16'd2}
  };

  logic [63:0] last_rsp;

  task automatic start_cmd(input bit rd, input logic [7:0] a, input int n,
                           input logic [63:0] d, input logic [63:0] r,
                           input int stall, input int lim);
    exp_tx_total = eff_n(rd, n) + 1;
    resp_word    = rd ? r : {8'hA5, 56'h0};
    resp_n       = rd ? 8 : 1;
    stall_cfg    = stall;
    @(negedge clk) clr_log = 1'b1;
    @(negedge clk) clr_log = 1'b0;
    cmd_valid   = 1'b1;
    cmd_is_read = rd;
    cmd_addr    = a;
    cmd_len     = rd ? 4'd7 : 4'(n);
    cmd_req_len = rd ? 4'(n) : 4'd3;
    cmd_data    = d;
    poll_limit  = 16'(lim);
    @(negedge clk) cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic do_reset_and_init();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1 && done == 1'b0 && timeout_err == 1'b0,
        "R1 reset flags", {69'h0, busy, done, timeout_err}, 72'h4);
    chk(rsp_data == 64'h0 && !bus_we && !bus_re, "R1 reset outputs",
        {rsp_data, 6'h0, bus_we, bus_re}, 72'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy during start-up", {71'h0, busy}, 72'h1);
    for (int i = 0; i < 50; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    chk(busy == 1'b0 && init_cnt == 4, "R1 start-up completes",
        {39'h0, busy, 32'(init_cnt)}, 72'h4);
    chk(init_log == 64'h0007_0100_030D_0207, "R1 start-up writes",
        {8'h0, init_log}, {8'h0, 64'h0007_0100_030D_0207});
  endtask

  initial begin
    bit got;
    int n;
    int d0;
    cmd_valid = 1'b0; cmd_is_read = 1'b0; cmd_addr = '0; cmd_len = '0;
    cmd_req_len = '0; cmd_data = '0; poll_limit = '0;
    last_rsp = '0;

    do_reset_and_init();

    // table-driven commands
    for (int v = 0; v < NV; v++) begin
      n  = eff_n(VECS[v].rd, int'(VECS[v].n));
      d0 = done_cnt;
      start_cmd(VECS[v].rd, VECS[v].addr, int'(VECS[v].n), VECS[v].data,
                VECS[v].resp, int'(VECS[v].stall), int'(VECS[v].lim));
      chk(busy == 1'b1, "R7 busy after accept", {71'h0, busy}, 72'h1);
      wait_done(got);
      chk(got && busy == 1'b0, "R7 done with busy low", {70'h0, got, busy}, 72'h2);
      @(negedge clk);
      chk(done == 1'b0 && done_cnt == d0 + 1, "R7 single done pulse",
          {39'h0, done, 32'(done_cnt - d0)}, 72'h1);
      if (VECS[v].rd) begin
        chk(tx_cnt == n + 1 && tx_log == exp_stream(VECS[v].addr, n, VECS[v].data),
            "R6 request bytes", tx_log, exp_stream(VECS[v].addr, n, VECS[v].data));
        chk(rd_cnt == 8 && q_cnt == 0, "R6 eight response reads",
            72'(rd_cnt), 72'd8);
        chk(rsp_data == VECS[v].resp, "R6 assembled response",
            {8'h0, rsp_data}, {8'h0, VECS[v].resp});
        last_rsp = VECS[v].resp;
      end else begin
        chk(tx_cnt == n + 1 && tx_log == exp_stream(VECS[v].addr, n, VECS[v].data),
            "R4 write bytes", tx_log, exp_stream(VECS[v].addr, n, VECS[v].data));
        chk(rd_cnt == 1 && q_cnt == 0, "R5 acknowledge drained",
            72'(rd_cnt), 72'd1);
        chk(rsp_data == last_rsp, "R5 response untouched",
            {8'h0, rsp_data}, {8'h0, last_rsp});
      end
      chk(viol == 0, "R2 R3 polled before each byte", 72'(viol), 72'd0);
      chk(timeout_err == 1'b0, "R10 no timeout within limit",
          {71'h0, timeout_err}, 72'h0);
    end
    chk(viol9 == 0, "R9 strobe shape", 72'(viol9), 72'd0);

    // R8: a command during busy is ignored
    d0 = done_cnt;
    start_cmd(1'b0, 8'hC1, 2, 64'h5A6B, 64'h0, 5, 20);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_is_read = 1'b1; cmd_addr = 8'hEE; cmd_req_len = 4'd1;
    @(negedge clk) cmd_valid = 1'b0;
    wait_done(got);
    repeat (30) @(negedge clk);
    chk(done_cnt == d0 + 1 && !busy, "R8 one completion only",
        72'(done_cnt - d0), 72'd1);
    chk(tx_log == exp_stream(8'hC1, 2, 64'h5A6B) && rd_cnt == 1,
        "R8 stream unaffected", tx_log, exp_stream(8'hC1, 2, 64'h5A6B));

    // R10: timeout after limit+1 not-ready replies
    d0 = done_cnt;
    start_cmd(1'b0, 8'hD2, 1, 64'h77, 64'h0, 40, 3);
    for (int i = 0; i < 200; i++) begin
      if (timeout_err) break;
      @(negedge clk);
    end
    @(negedge clk);
    chk(timeout_err == 1'b1 && busy == 1'b0, "R10 timeout raised",
        {70'h0, timeout_err, busy}, 72'h2);
    chk(done_cnt == d0 && tx_cnt == 0, "R10 no transfer no done",
        {40'h0, 32'(done_cnt - d0)}, 72'h0);

    // R10: flag sticks across a later good command
    start_cmd(1'b0, 8'hE3, 1, 64'h39, 64'h0, 0, 2);
    wait_done(got);
    @(negedge clk);
    chk(got && timeout_err == 1'b1, "R10 flag sticky",
        {70'h0, got, timeout_err}, 72'h3);
    chk(tx_log == exp_stream(8'hE3, 1, 64'h39), "R4 after timeout",
        tx_log, exp_stream(8'hE3, 1, 64'h39));

    // second reset clears the flag and repeats start-up
    do_reset_and_init();
    chk(timeout_err == 1'b0, "R1 flag cleared by reset",
        {71'h0, timeout_err}, 72'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule